// File: doc/BRIEF.md
# Comparator Output Conditioner

This block sits between a digital comparator decision and the logic that uses it in a small microcontroller-style peripheral set. It can invert the decision. It can also hold it steady by capturing it on the falling edge of the timer's counting clock, which is taken after the prescaler. The conditioned value is used as a status bit and can serve as the gate for that timer. The same value, before any capture, can be routed to an I/O pin.

The timer counts on rising edges of its clock and this block samples on falling edges. The gate therefore never changes during an increment. A small configuration register on the system clock selects the gate source and enables the capture. Of its 8 bits only two are implemented.

Top module: `cmpout_conditioner`

## Requirements
- R1: After reset, `reg_rdata` reads 8'h02. That is gate-source select (bit 1) = 1 and capture enable (bit 0) = 0.
- R2: A write with `reg_we` high at a rising `clk` edge loads bit 1 and bit 0 of `reg_wdata`. Bits 7 to 2 are ignored and always read 0.
- R3: With capture disabled, `cmp_status` equals `cmp_raw XOR pol_inv` with no clock delay.
- R4: With capture enabled, `cmp_status` takes the value `cmp_raw XOR pol_inv` had at the most recent falling edge of `tmr_clk`. It changes at no other time. The capture register resets to 0.
- R5: `tmr_gate` equals `gate_pin` when bit 1 is 1. When bit 1 is 0, `tmr_gate` equals `cmp_status`.
- R6: `pad_out` is `cmp_raw XOR pol_inv`, never the captured value, when `pin_route_en` is 1. Otherwise `pad_out` is `gpio_dout`. This holds whatever the capture enable is set to.
- R7: `pad_oe` is the inverse of `pad_tris`, in every routing mode.
- R8: With capture enabled and the comparator selected as gate, a change in `cmp_raw` between a rising and the next falling edge of `tmr_clk` reaches `tmr_gate` only at that falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the configuration register |
| rst_n | input | 1 | Active-low synchronous reset, seen by both clocks |
| reg_we | input | 1 | Configuration write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration read data |
| cmp_raw | input | 1 | Raw comparator decision |
| pol_inv | input | 1 | Invert the decision when 1 |
| tmr_clk | input | 1 | Timer counting clock after the prescaler |
| gate_pin | input | 1 | External gate pin level |
| pin_route_en | input | 1 | Route the decision to the pad when 1 |
| gpio_dout | input | 1 | Ordinary pin data when not routed |
| pad_tris | input | 1 | Tristate control, 1 = pad not driven |
| pad_out | output | 1 | Pad data |
| pad_oe | output | 1 | Pad driver enable |
| cmp_status | output | 1 | Conditioned decision for status reads |
| tmr_gate | output | 1 | Gate signal to the timer |

## Verification
The assertions on the captured path sample `tmr_clk` with the system clock. They therefore assume that `tmr_clk` is much slower than `clk`, so that no full timer pulse fits between two system edges. The bench toggles `tmr_clk` only once every few system cycles. It also changes `cmp_raw` and `pol_inv` a couple of nanoseconds after any timer edge, never on the edge itself, so the captured value is never ambiguous. Register writes are random bytes, so the ignored upper bits are exercised.

// File: rtl/cmpc_pkg.sv
`timescale 1ns/1ps
// Shared parameters and types for the comparator output conditioner.
package cmpc_pkg;
    localparam int REG_W    = 8;  // configuration register width
    localparam int GATE_BIT = 1;  // gate-source select position
    localparam int SYNC_BIT = 0;  // capture enable position

    typedef struct packed {
        logic gate_ext;   // 1 = external gate pin, 0 = comparator
        logic sync_en;    // 1 = capture on falling timer clock
    } cmpc_cfg_t;

    localparam cmpc_cfg_t CFG_RESET = '{gate_ext: 1'b1, sync_en: 1'b0};
endpackage

// File: rtl/cmpc_cfg_reg.sv
`timescale 1ns/1ps
// Configuration register: two implemented bits at fixed positions.
// All other bits ignore writes and read back as 0.
// Assumes reg_we is synchronous to clk.
module cmpc_cfg_reg
    import cmpc_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int GB = GATE_BIT,
    parameter int SB = SYNC_BIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output cmpc_cfg_t    cfg
);
    cmpc_cfg_t cfg_q;

    // Load the two implemented bits on a write; reset to the defined default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (we) begin
            cfg_q.gate_ext <= wdata[GB];
            cfg_q.sync_en  <= wdata[SB];
        end
    end

    // Build the read word; unimplemented positions are tied to 0.
    generate
        for (genvar i = 0; i < W; i++) begin : g_rd
            if (i == GB) begin : g_gate
                assign rdata[i] = cfg_q.gate_ext;
            end else if (i == SB) begin : g_sync
                assign rdata[i] = cfg_q.sync_en;
            end else begin : g_zero
                assign rdata[i] = 1'b0;
            end
        end
    endgenerate

    logic unused_wbits;
    assign unused_wbits = ^wdata;
    assign cfg = cfg_q;

    // A write lands in the implemented bits on the next edge.
    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg_q.gate_ext == $past(wdata[GB]) && cfg_q.sync_en == $past(wdata[SB])));
    // Without a write the configuration holds.
    assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_q));
endmodule

// File: rtl/cmpc_fall_latch.sv
`timescale 1ns/1ps
// Captures the conditioned decision on the falling edge of the timer
// clock (post-prescaler), opposite to the timer's rising-edge count.
// Assumes rst_n is held across at least one falling timer edge.
module cmpc_fall_latch (
    input  logic tmr_clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    // Sample the decision on every falling timer edge.
    always_ff @(negedge tmr_clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
    end
endmodule

// File: rtl/cmpc_route.sv
`timescale 1ns/1ps
// Output steering: picks the live or captured decision and the gate source,
// and drives the pad from either the live decision or ordinary pin data.
module cmpc_route
    import cmpc_pkg::*;
(
    input  cmpc_cfg_t cfg,
    input  logic      live,
    input  logic      held,
    input  logic      gate_pin,
    input  logic      pin_route_en,
    input  logic      gpio_dout,
    input  logic      pad_tris,
    output logic      status,
    output logic      gate,
    output logic      pad_out,
    output logic      pad_oe
);
    // Pick the conditioned decision, then the gate source.
    always_comb begin
        status = cfg.sync_en ? held : live;
        gate   = cfg.gate_ext ? gate_pin : status;
    end

    // Pad path always uses the live decision; tristate still gates the driver.
    always_comb begin
        pad_out = pin_route_en ? live : gpio_dout;
        pad_oe  = ~pad_tris;
    end
endmodule

// File: rtl/cmpout_conditioner.sv
`timescale 1ns/1ps
// Comparator output conditioner top. Applies polarity, optional capture on
// the falling timer clock, gate selection and pad routing.
// Assumes tmr_clk is much slower than clk.
module cmpout_conditioner
    import cmpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmp_raw,
    input  logic             pol_inv,
    input  logic             tmr_clk,
    input  logic             gate_pin,
    input  logic             pin_route_en,
    input  logic             gpio_dout,
    input  logic             pad_tris,
    output logic             pad_out,
    output logic             pad_oe,
    output logic             cmp_status,
    output logic             tmr_gate
);
    cmpc_cfg_t cfg;
    logic      live;
    logic      held;

    // Polarity is applied ahead of every consumer.
    assign live = cmp_raw ^ pol_inv;

    cmpc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    cmpc_fall_latch u_latch (
        .tmr_clk (tmr_clk),
        .rst_n   (rst_n),
        .d       (live),
        .q       (held)
    );

    cmpc_route u_route (
        .cfg          (cfg),
        .live         (live),
        .held         (held),
        .gate_pin     (gate_pin),
        .pin_route_en (pin_route_en),
        .gpio_dout    (gpio_dout),
        .pad_tris     (pad_tris),
        .status       (cmp_status),
        .gate         (tmr_gate),
        .pad_out      (pad_out),
        .pad_oe       (pad_oe)
    );

    // Captured status moves only across a timer clock transition.
    assert_hold_between_edges_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sync_en && $past(cfg.sync_en) && tmr_clk == $past(tmr_clk)) |-> $stable(cmp_status));
    // Untimed mode follows the polarity-adjusted input directly.
    assert_untimed_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.sync_en |-> (cmp_status == (cmp_raw ^ pol_inv)));
    // External gate selection passes the pin through.
    assert_gate_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.gate_ext |-> (tmr_gate == gate_pin));
    // Comparator gate selection follows the status value.
    assert_gate_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.gate_ext |-> (tmr_gate == cmp_status));
endmodule

// File: tb/sim_cmpout_conditioner.sv
`timescale 1ns/1ps
module sim_cmpout_conditioner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cmp_raw = 1'b0, pol_inv = 1'b0, tmr_clk = 1'b1, gate_pin = 1'b0;
    logic       pin_route_en = 1'b0, gpio_dout = 1'b0, pad_tris = 1'b1;
    logic       pad_out, pad_oe, cmp_status, tmr_gate;

    int  n_run = 0, n_fail = 0;
    bit  finished = 0;
    logic exp_gate_ext = 1'b1, exp_sync_en = 1'b0, exp_held = 1'b0;
    logic we_pend = 1'b0;
    logic [7:0] wd_pend = 8'h00;

    always #10 clk = ~clk;

    cmpout_conditioner u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_status();
        return exp_sync_en ? exp_held : (cmp_raw ^ pol_inv);
    endfunction

    // One system step: retire pending write, optionally toggle the timer clock.
    task automatic tick(input bit tmr_toggle);
        @(negedge clk);
        if (we_pend) begin
            exp_gate_ext = wd_pend[1];
            exp_sync_en  = wd_pend[0];
        end
        we_pend = 1'b0;
        reg_we  = 1'b0;
        if (tmr_toggle) begin
            tmr_clk = ~tmr_clk;
            if (!tmr_clk && rst_n) exp_held = cmp_raw ^ pol_inv;
        end
        #2;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v; we_pend = 1'b1; wd_pend = v;
        tick(1'b0);
    endtask

    // Compare every output with the model.
    task automatic check_all();
        logic s, g, p;
        #2;
        s = exp_status();
        g = exp_gate_ext ? gate_pin : s;
        p = pin_route_en ? (cmp_raw ^ pol_inv) : gpio_dout;
        chk(reg_rdata == {6'b0, exp_gate_ext, exp_sync_en}, "R2 rdata", reg_rdata, {6'b0, exp_gate_ext, exp_sync_en});
        chk(cmp_status == s, exp_sync_en ? "R4 captured status" : "R3 live status", {7'b0, cmp_status}, {7'b0, s});
        chk(tmr_gate == g, "R5 gate", {7'b0, tmr_gate}, {7'b0, g});
        chk(pad_out == p, "R6 pad_out", {7'b0, pad_out}, {7'b0, p});
        chk(pad_oe == !pad_tris, "R7 pad_oe", {7'b0, pad_oe}, {7'b0, !pad_tris});
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        // Reset with a falling timer edge inside it.
        tick(1'b0); tick(1'b1); tick(1'b0); tick(1'b1);
        @(negedge clk); rst_n = 1'b1; #2;
        // R1: reset value of the register and the capture register.
        chk(reg_rdata == 8'h02, "R1 reset rdata", reg_rdata, 8'h02);
        write_cfg(8'h01);
        #2;
        chk(cmp_status == 1'b0, "R4 capture reset value", {7'b0, cmp_status}, 8'h00);
        // R2: upper bits ignored.
        write_cfg(8'hFF); check_all();
        chk(reg_rdata == 8'h03, "R2 upper bits read 0", reg_rdata, 8'h03);
        write_cfg(8'hFC); check_all();
        chk(reg_rdata == 8'h00, "R2 upper bits ignored", reg_rdata, 8'h00);
        // R3: untimed path with both polarities.
        cmp_raw = 1'b1; pol_inv = 1'b0; #1;
        chk(cmp_status == 1'b1, "R3 no invert", {7'b0, cmp_status}, 8'h01);
        pol_inv = 1'b1; #1;
        chk(cmp_status == 1'b0, "R3 invert", {7'b0, cmp_status}, 8'h00);
        // R6: pad uses live value even with capture on.
        write_cfg(8'h01);
        pin_route_en = 1'b1; pad_tris = 1'b0; cmp_raw = 1'b0; pol_inv = 1'b0; #1;
        chk(pad_out == 1'b0, "R6 live low", {7'b0, pad_out}, 8'h00);
        cmp_raw = 1'b1; #1;
        chk(pad_out == 1'b1, "R6 live not captured", {7'b0, pad_out}, 8'h01);
        chk(pad_oe == 1'b1, "R7 driver on", {7'b0, pad_oe}, 8'h01);
        // R8: change between rising and falling edge reaches gate at the fall.
        cmp_raw = 1'b0;
        tick(1'b0);
        if (!tmr_clk) tick(1'b1);          // make sure the clock is high
        tick(1'b1); tick(1'b1);            // fall then rise: held = 0
        #1;
        chk(tmr_gate == 1'b0, "R8 before change", {7'b0, tmr_gate}, 8'h00);
        cmp_raw = 1'b1;
        tick(1'b0); #1;
        chk(tmr_gate == 1'b0, "R8 change not yet seen", {7'b0, tmr_gate}, 8'h00);
        tick(1'b1); #1;
        chk(tmr_gate == 1'b1, "R8 seen after falling edge", {7'b0, tmr_gate}, 8'h01);
        check_all();
        // Random mix.
        for (int i = 0; i < 3000; i++) begin
            tick((i % 3) == 0);
            if ($urandom_range(0, 15) == 0) begin
                reg_we = 1'b1; reg_wdata = 8'($urandom); we_pend = 1'b1; wd_pend = reg_wdata;
            end
            cmp_raw      = 1'($urandom);
            if ($urandom_range(0, 7) == 0) pol_inv = ~pol_inv;
            gate_pin     = 1'($urandom);
            pin_route_en = 1'($urandom);
            gpio_dout    = 1'($urandom);
            pad_tris     = 1'($urandom);
            check_all();
        end
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule